// File: doc/BRIEF.md
# Processor Supervisor: Watchdog and Reset Generator

This block watches over a host processor and drives one reset line to it. Reset is asserted whenever the supply is not trustworthy: from the moment power-good falls until a fixed hold period has passed after it rises, and at any time the external low-supply comparator output is high, again followed by a full hold period once that indication clears. All periods are counted in ticks of an internal prescaled timebase, so simulation can use short values while silicon uses long ones.

The block also runs a watchdog. The host restarts it by pulling the shared chip-select/watchdog line from high to low. A line held steady at either level, or a line that only rises, restarts nothing. If no falling edge arrives within the selected timeout, the block asserts reset for the hold period, sets a volatile flag recording that the watchdog caused it, and then starts the watchdog again from zero. The timeout choice comes from a two-bit setting that a persistent configuration store supplies as a register. The host clears the flag through a register-write strobe, and loss of power-good also clears it.

The control is a three-state machine. In HOLD, reset is asserted and the hold counter runs. In RUN, reset is released and the watchdog counter runs. In LOWV, reset is asserted while supply is low. It has four transitions. T_HOLD_DONE goes from HOLD to RUN when the hold period ends. T_WD_EXPIRE goes from RUN to HOLD on a timeout. T_LOW_ENTER goes from any state to LOWV when the supply goes low. T_LOW_EXIT goes from LOWV to HOLD when the supply recovers. Loss of power-good forces HOLD asynchronously.

Top module: `sup_wd_reset`

## Requirements
- R1: While power_good is low, reset is active and wd_flag is 0. After power_good rises, reset stays active for exactly HOLD_TICKS*PRESCALE clock edges and is released on the last of them.
- R2: A high supply_low sampled at a clock edge makes reset active after that edge, and reset stays active for as long as supply_low stays high.
- R3: When supply_low returns low, reset is released HOLD_TICKS*PRESCALE+1 edges after the first edge that samples it low. Edges seen on cs_wdi during this period have no effect on that timing.
- R4: Only a high-to-low change on cs_wdi restarts the watchdog, and it takes effect on the third clock edge after the change (two-flop synchroniser plus edge register). A rising change, a steady high and a steady low do not restart it.
- R5: wd_sel encodes the timeout: 2'b01 gives TO_SHORT ticks, 2'b10 gives TO_MID and 2'b11 gives TO_LONG. Reset becomes active exactly timeout*PRESCALE edges after reset release or after the last restart.
- R6: wd_sel = 2'b00 disables the watchdog: no watchdog reset occurs and wd_flag does not rise, however long cs_wdi stays idle.
- R7: After a watchdog timeout, reset stays active for exactly HOLD_TICKS*PRESCALE edges and ignores cs_wdi edges during that time. The watchdog then restarts from zero.
- R8: wd_flag rises on the same edge that a watchdog timeout asserts reset.
- R9: wd_flag is cleared on the edge after flag_clr is sampled high and whenever power_good is low. A low-supply reset leaves it unchanged.
- R10: With ACTIVE_LOW = 1, rst_out is 0 while reset is active. With ACTIVE_LOW = 0 it is 1 while reset is active. Timing is identical in both builds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescaler derives timebase ticks from it |
| power_good | input | 1 | Power-good indication, low forces power-up reset (asynchronous) |
| supply_low | input | 1 | Digital output of the external low-supply comparator, high when supply is below trip |
| cs_wdi | input | 1 | Shared chip-select / watchdog line, asynchronous; falling edges restart the watchdog |
| wd_sel | input | 2 | Watchdog timeout setting from persistent configuration (00 off, 01/10/11 short/mid/long) |
| flag_clr | input | 1 | Host register-write strobe that clears the watchdog flag |
| rst_out | output | 1 | Reset to the host processor, polarity set by ACTIVE_LOW |
| wd_flag | output | 1 | Volatile flag, 1 when the last reset came from a watchdog timeout |

## Verification
On every cycle, the assertions check the local links between inputs and outputs. These are: a low supply forcing reset on the next edge, release never following a low-supply sample, the flag rising only together with reset, the flag falling only after a clear strobe, and no flag rise while the watchdog is disabled. Exact durations need the directed scenarios: the hold length after power-up, low supply and timeout, the three timeout lengths, and the three-edge kick latency. So do the facts that rising edges and steady levels fail to kick and that kicks during reset are ignored. The same holds for flag retention across a low-supply reset and for the polarity of the second build.

// File: rtl/sup_wd_pkg.sv
package sup_wd_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOWV = 2'd2
    } sup_state_t;

    localparam logic [1:0] WD_OFF   = 2'b00;
    localparam logic [1:0] WD_SHORT = 2'b01;
    localparam logic [1:0] WD_MID   = 2'b10;
    localparam logic [1:0] WD_LONG  = 2'b11;

endpackage

// File: rtl/sup_cs_sync.sv
module sup_cs_sync (
    input  logic clk,
    input  logic arst_n,
    input  logic pin,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;
endmodule

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] cnt;

    assign tick = (cnt == PRE_LAST);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)      cnt <= '0;
        else if (restart) cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sup_wd_reset.sv
module sup_wd_reset
    import sup_wd_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1,
    parameter int PRESCALE   = 4,
    parameter int HOLD_TICKS = 6,
    parameter int TO_SHORT   = 5,
    parameter int TO_MID     = 10,
    parameter int TO_LONG    = 20
) (
    input  logic       clk,
    input  logic       power_good,
    input  logic       supply_low,
    input  logic       cs_wdi,
    input  logic [1:0] wd_sel,
    input  logic       flag_clr,
    output logic       rst_out,
    output logic       wd_flag
);
    localparam int TO_MAX = (TO_LONG > TO_MID)
                          ? ((TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT)
                          : ((TO_MID  > TO_SHORT) ? TO_MID  : TO_SHORT);
    localparam int WD_W   = $clog2(TO_MAX + 1);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);
    localparam logic [WD_W-1:0]   WD_TOP    = WD_W'(TO_MAX);

    sup_state_t        state, state_nxt;
    logic [HOLD_W-1:0] hold_cnt;
    logic [WD_W-1:0]   wd_cnt;
    logic [WD_W-1:0]   to_ticks;
    logic              wd_en;
    logic              tick, kick, restart;
    logic              hold_done, expire;
    logic              rst_active;

    sup_cs_sync u_sync (
        .clk    (clk),
        .arst_n (power_good),
        .pin    (cs_wdi),
        .fall   (kick)
    );

    sup_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .arst_n  (power_good),
        .restart (restart),
        .tick    (tick)
    );

    always_comb begin
        unique case (wd_sel)
            WD_SHORT: to_ticks = WD_W'(TO_SHORT);
            WD_MID:   to_ticks = WD_W'(TO_MID);
            WD_LONG:  to_ticks = WD_W'(TO_LONG);
            default:  to_ticks = WD_W'(TO_MAX);
        endcase
    end
    assign wd_en = (wd_sel != WD_OFF);

    assign hold_done = (state == ST_HOLD) && tick && (hold_cnt == HOLD_LAST);
    assign expire    = (state == ST_RUN) && !supply_low && wd_en && !kick
                       && tick && (wd_cnt >= to_ticks - 1'b1);

    // transitions: T_LOW_ENTER, T_LOW_EXIT, T_HOLD_DONE, T_WD_EXPIRE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (supply_low)     state_nxt = ST_LOWV;
                else if (hold_done) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (supply_low)     state_nxt = ST_LOWV;
                else if (expire)    state_nxt = ST_HOLD;
            end
            ST_LOWV: begin
                if (!supply_low)    state_nxt = ST_HOLD;
            end
            default:                state_nxt = ST_HOLD;
        endcase
    end

    assign restart = (state_nxt != state) || ((state == ST_RUN) && kick);

    always_ff @(posedge clk or negedge power_good) begin
        if (!power_good) state <= ST_HOLD;
        else             state <= state_nxt;
    end

    always_ff @(posedge clk or negedge power_good) begin
        if (!power_good) begin
            hold_cnt <= '0;
            wd_cnt   <= '0;
            wd_flag  <= 1'b0;
        end else begin
            if (state != ST_HOLD || state_nxt != ST_HOLD) hold_cnt <= '0;
            else if (tick)                                hold_cnt <= hold_cnt + 1'b1;

            if (state != ST_RUN || restart || !wd_en)     wd_cnt <= '0;
            else if (tick && wd_cnt < WD_TOP)             wd_cnt <= wd_cnt + 1'b1;

            if (expire)        wd_flag <= 1'b1;
            else if (flag_clr) wd_flag <= 1'b0;
        end
    end

    always_comb begin
        rst_active = (state != ST_RUN);
    end

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign rst_out = ~rst_active;
        end else begin : g_pol_high
            assign rst_out = rst_active;
        end
    endgenerate
endmodule

// File: rtl/sup_wd_reset_chk.sv
module sup_wd_reset_chk #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic       clk,
    input logic       power_good,
    input logic       supply_low,
    input logic [1:0] wd_sel,
    input logic       flag_clr,
    input logic       rst_out,
    input logic       wd_flag
);
    logic rst_act;
    assign rst_act = ACTIVE_LOW ? ~rst_out : rst_out;

    assert_low_forces_reset_R2: assert property (@(posedge clk) disable iff (!power_good)
        supply_low |=> rst_act);

    assert_no_release_in_low_R3: assert property (@(posedge clk) disable iff (!power_good)
        $fell(rst_act) |-> !$past(supply_low));

    assert_off_no_flag_R6: assert property (@(posedge clk) disable iff (!power_good)
        (wd_sel == 2'b00) |=> !$rose(wd_flag));

    assert_flag_with_reset_R8: assert property (@(posedge clk) disable iff (!power_good)
        $rose(wd_flag) |-> rst_act);

    assert_flag_clear_cause_R9: assert property (@(posedge clk) disable iff (!power_good)
        $fell(wd_flag) |-> $past(flag_clr));
endmodule

bind sup_wd_reset sup_wd_reset_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk        (clk),
    .power_good (power_good),
    .supply_low (supply_low),
    .wd_sel     (wd_sel),
    .flag_clr   (flag_clr),
    .rst_out    (rst_out),
    .wd_flag    (wd_flag)
);

// File: tb/test_sup_wd_reset.sv
module test_sup_wd_reset;
    localparam int P  = 4;
    localparam int H  = 6;
    localparam int T0 = 5;
    localparam int T1 = 10;
    localparam int T2 = 20;
    localparam int HC = H * P;

    logic       clk = 1'b0;
    logic       power_good = 1'b0;
    logic       supply_low = 1'b0;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_sel = 2'b01;
    logic       flag_clr = 1'b0;
    logic       rst_lo, rst_hi, flag_lo, flag_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    sup_wd_reset #(.ACTIVE_LOW(1'b1), .PRESCALE(P), .HOLD_TICKS(H),
                   .TO_SHORT(T0), .TO_MID(T1), .TO_LONG(T2)) i_sup_wd_reset (
        .clk(clk), .power_good(power_good), .supply_low(supply_low), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .flag_clr(flag_clr), .rst_out(rst_lo), .wd_flag(flag_lo));

    sup_wd_reset #(.ACTIVE_LOW(1'b0), .PRESCALE(P), .HOLD_TICKS(H),
                   .TO_SHORT(T0), .TO_MID(T1), .TO_LONG(T2)) i_sup_wd_reset_hi (
        .clk(clk), .power_good(power_good), .supply_low(supply_low), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .flag_clr(flag_clr), .rst_out(rst_hi), .wd_flag(flag_hi));

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reset activity from both builds (R10: active-high build mirrors)
    task automatic chk_rst(input bit exp_act, input string tag);
        chk((~rst_lo) == exp_act, tag, int'(~rst_lo), int'(exp_act));
        chk(rst_hi == exp_act, {tag, " R10"}, int'(rst_hi), int'(exp_act));
    endtask

    task automatic chk_flag(input bit exp, input string tag);
        chk(flag_lo == exp && flag_hi == exp, tag, int'(flag_lo), int'(exp));
    endtask

    task automatic wait_release(input string tag);
        step(HC - 1);
        chk_rst(1'b1, tag);
        step(1);
        chk_rst(1'b0, tag);
    endtask

    task automatic t_powerup();
        step(3);
        chk_rst(1'b1, "R1 reset while power bad");
        chk_flag(1'b0, "R1 flag zero at reset");
        power_good = 1'b1;
        wait_release("R1 power-up hold");
    endtask

    task automatic t_wd_expire_short();
        step(T0 * P - 1);
        chk_rst(1'b0, "R5 short timeout not yet");
        chk_flag(1'b0, "R8 flag before timeout");
        step(1);
        chk_rst(1'b1, "R5 short timeout fires");
        chk_flag(1'b1, "R8 flag set with reset");
    endtask

    task automatic t_hold_ignores_kick();
        cs_wdi = 1'b0;
        step(3);
        cs_wdi = 1'b1;
        step(HC - 4);
        chk_rst(1'b1, "R7 hold after timeout");
        step(1);
        chk_rst(1'b0, "R7 release after hold");
        step(T0 * P - 1);
        chk_rst(1'b0, "R7 watchdog restart from zero");
        step(1);
        chk_rst(1'b1, "R7 second timeout");
        wait_release("R7 hold again");
    endtask

    task automatic t_kicks_and_rise();
        bit seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            cs_wdi = ((i % 10) < 5) ? 1'b0 : 1'b1;
            step(1);
            if (!rst_lo) seen = 1'b1;
        end
        chk(!seen, "R4 regular falling edges keep reset off", int'(seen), 0);
        cs_wdi = 1'b0;
        step(5);
        cs_wdi = 1'b1;
        step(17);
        chk_rst(1'b0, "R4 rise does not kick, before expiry");
        step(1);
        chk_rst(1'b1, "R4 expiry measured from last fall");
        wait_release("R7 hold");
        chk_flag(1'b1, "R9 flag kept");
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk_flag(1'b0, "R9 host clear");
    endtask

    task automatic t_steady_levels();
        cs_wdi = 1'b0;
        step(22);
        chk_rst(1'b0, "R4 steady low before expiry");
        step(1);
        chk_rst(1'b1, "R4 steady low fails");
        chk_flag(1'b1, "R8 flag after steady low");
        step(HC - 1);
        cs_wdi = 1'b1;
        step(1);
        chk_rst(1'b0, "R7 release");
        step(T0 * P - 1);
        chk_rst(1'b0, "R4 steady high before expiry");
        step(1);
        chk_rst(1'b1, "R4 steady high fails");
    endtask

    task automatic t_select();
        wd_sel = 2'b10;
        step(HC);
        step(T1 * P - 1);
        chk_rst(1'b0, "R5 mid timeout not yet");
        step(1);
        chk_rst(1'b1, "R5 mid timeout fires");
        wd_sel = 2'b11;
        step(HC);
        step(T2 * P - 1);
        chk_rst(1'b0, "R5 long timeout not yet");
        step(1);
        chk_rst(1'b1, "R5 long timeout fires");
        wait_release("R7 hold after long");
    endtask

    task automatic t_lowv();
        supply_low = 1'b1;
        step(1);
        chk_rst(1'b1, "R2 low supply asserts");
        step(2 * HC);
        chk_rst(1'b1, "R2 held while low");
        chk_flag(1'b1, "R9 low reset keeps flag");
        supply_low = 1'b0;
        cs_wdi = 1'b0;
        step(3);
        cs_wdi = 1'b1;
        step(HC - 3);
        chk_rst(1'b1, "R3 hold after recovery");
        step(1);
        chk_rst(1'b0, "R3 release after recovery");
        chk_flag(1'b1, "R9 flag after low reset");
    endtask

    task automatic t_disabled();
        wd_sel = 2'b00;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        step(8 * T2 * P);
        chk_rst(1'b0, "R6 disabled no reset");
        chk_flag(1'b0, "R6 disabled no flag");
    endtask

    task automatic t_power_loss();
        wd_sel = 2'b01;
        step(T0 * P);
        chk_flag(1'b1, "R8 flag set again");
        power_good = 1'b0;
        step(1);
        chk_flag(1'b0, "R9 power loss clears flag");
        chk_rst(1'b1, "R1 power loss asserts");
        power_good = 1'b1;
        wait_release("R1 second power-up");
    endtask

    initial begin
        @(negedge clk);
        t_powerup();
        t_wd_expire_short();
        t_hold_ignores_kick();
        t_kicks_and_rise();
        t_steady_levels();
        t_select();
        t_lowv();
        t_disabled();
        t_power_loss();
        finish_run();
    end
endmodule